// File: doc/BRIEF.md
# DRAM Command Spacing Gate

The gate sits between a memory command scheduler and the DRAM command bus. Each cycle the scheduler offers at most one command: an activate, a read or a write, with a DIMM number and a rank number. In the same cycle the gate answers whether that command may go out under the programmed spacing rules. A command counts as issued only in a cycle where the request is valid and the gate allows it. Only issued commands update the gate's history.

A 21-bit timing word supplies every rule, and all of its values count DRAM clock cycles. The rules are as follows. Column commands (reads and writes) keep a minimum spacing between them. The gap between two writes depends on where the new write goes compared with the previous one: the same rank, another rank on the same DIMM, or another DIMM. Activates to a single rank keep a minimum gap. No rank may take more than four activates inside a rolling window. The scheduler keeps the timing word stable while commands are in flight.

Top module: `dram_spacing_gate`

## Requirements
- R1: After reset, with a timing word of all zeros and no command issued yet, every command type is allowed at once. Back-to-back column commands issue on consecutive cycles.
- R2: The column spacing setting is in word bits 20:16 and holds the required gap minus one. For a setting s from 3 to 31, any two issued reads or writes, to any rank, are at least s+1 cycles apart. The second one is allowed in exactly the cycle that reaches that gap.
- R3: Column spacing settings of 0, 1 and 2 place no limit on reads or writes.
- R4: A write to a different DIMM from the previous write must wait code+2 cycles. The code is in bits 15:13, so codes 0 to 7 give 2 to 9 cycles.
- R5: A write to another rank on the same DIMM as the previous write must wait code+2 cycles. The code is in bits 12:10.
- R6: A write to the same rank as the previous write must wait 4 cycles when bit 9 is 0 and 6 cycles when bit 9 is 1. The two locality codes above do not apply in this case.
- R7: Two activates to the same rank are at least the value in bits 8:6 apart, and a value of 0 means no limit. Activates to other ranks are not held back by this rule.
- R8: A rank takes at most four activates within any window of w cycles, where w is in bits 5:0. A fifth activate is allowed once the first of the last four is w or more cycles old. A value of 0 turns the rule off, and each rank is tracked on its own.
- R9: The grant is combinational in the request cycle. A command is never held back once every rule that applies to it is met. A request that is not valid changes no history. Command type code 3 is reserved and is always allowed (codes: 0 activate, 1 read, 2 write, 3 reserved).
- R10: Reads take part in the column spacing rule but do not restart or replace the write-to-write history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all history |
| timing_word | input | 21 | Packed spacing settings (fields as in R2 to R8) |
| cmd_valid | input | 1 | Scheduler offers a command this cycle |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 reserved |
| dimm_id | input | DIMM_W (1) | Target DIMM |
| rank_id | input | RANK_W (1) | Target rank within the DIMM |
| issue_ok | output | 1 | Offered command may issue this cycle |

## Verification
Assertions check several properties on every cycle. No two column commands issue on adjacent cycles while a column spacing setting of 3 or more is active. No two writes ever issue back to back. An activate to a rank with a gap of 2 or more is never followed at once by another activate to that rank. Each rank's activate history stays ordered from newest to oldest, and the reserved command type is always granted. The exact gap lengths need the bench's scenarios: the gap chosen by write locality, the cycle in which a fifth activate frees up, the lack of any extra wait once the rules are met, and the fact that rejected or invalid requests leave the history alone.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2,
      CMD_RSV = 2'd3
   } dsg_cmd_e;

   // MSB-first packing matches timing word bits 20:0
   typedef struct packed {
      logic [4:0] cas_set;    // 20:16
      logic [2:0] wr_dimm;    // 15:13
      logic [2:0] wr_rank;    // 12:10
      logic       wr_same;    // 9
      logic [2:0] act_gap;    // 8:6
      logic [5:0] faw_len;    // 5:0
   } dsg_cfg_t;

   localparam int CFG_BITS     = $bits(dsg_cfg_t);
   localparam int CAS_MIN_SET  = 3;
   localparam int WR_GAP_BASE  = 2;
   localparam int WR_SAME_LO   = 4;
   localparam int WR_SAME_HI   = 6;

endpackage

// File: rtl/dsg_age_ctr.sv
module dsg_age_ctr #(
   parameter int AGE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   output logic [AGE_W-1:0] age_o,
   output logic             seen_o
);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   initial begin
      assert (AGE_W >= 2) else $error("dsg_age_ctr: AGE_W too small");
   end

   // age_o is the number of cycles since the last clear, saturating
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_o  <= '0;
         seen_o <= 1'b0;
      end else if (clear_i) begin
         age_o  <= AGE_W'(1);
         seen_o <= 1'b1;
      end else if (seen_o && (age_o != AGE_MAX)) begin
         age_o  <= age_o + AGE_W'(1);
      end
   end

   p_age_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_o && !clear_i) |=> (age_o >= $past(age_o)));

endmodule

// File: rtl/dsg_cas_gate.sv
module dsg_cas_gate #(
   parameter int SET_W = 5,
   parameter int MIN_SET = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] cas_set_i,
   input  logic             cas_fire_i,
   output logic             ok_o
);
   localparam int AGE_W = SET_W + 1;

   logic [AGE_W-1:0] age;
   logic             seen;
   logic             enforce;
   logic [AGE_W-1:0] need;

   initial begin
      assert (MIN_SET >= 1 && MIN_SET < (1 << SET_W))
         else $error("dsg_cas_gate: MIN_SET out of range");
   end

   dsg_age_ctr #(.AGE_W(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cas_fire_i),
      .age_o   (age),
      .seen_o  (seen)
   );

   always_comb begin
      enforce = (cas_set_i >= SET_W'(MIN_SET));
      need    = AGE_W'(cas_set_i) + AGE_W'(1);
      ok_o    = !enforce || !seen || (age >= need);
   end

   p_cas_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_fire_i && (cas_set_i >= SET_W'(MIN_SET)))
      |=> (!cas_fire_i || !$stable(cas_set_i)));

endmodule

// File: rtl/dsg_wr_gate.sv
module dsg_wr_gate #(
   parameter int NUM_DIMMS      = 2,
   parameter int RANKS_PER_DIMM = 2,
   parameter int DIMM_W         = 1,
   parameter int RANK_W         = 1,
   parameter int CODE_W         = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIMM_W-1:0] dimm_i,
   input  logic [RANK_W-1:0] rank_i,
   input  logic              same_code_i,
   input  logic [CODE_W-1:0] rank_code_i,
   input  logic [CODE_W-1:0] dimm_code_i,
   input  logic              wr_fire_i,
   output logic              ok_o
);
   import dsg_pkg::*;

   localparam int AGE_W = CODE_W + 2;

   logic [AGE_W-1:0]  age;
   logic              seen;
   logic [DIMM_W-1:0] last_dimm;
   logic [RANK_W-1:0] last_rank;
   logic              same_dimm;
   logic              same_rank;
   logic [AGE_W-1:0]  need;

   initial begin
      assert ((1 << AGE_W) > ((1 << CODE_W) - 1 + WR_GAP_BASE))
         else $error("dsg_wr_gate: age width too small for code range");
   end

   dsg_age_ctr #(.AGE_W(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (wr_fire_i),
      .age_o   (age),
      .seen_o  (seen)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_dimm <= '0;
         last_rank <= '0;
      end else if (wr_fire_i) begin
         last_dimm <= dimm_i;
         last_rank <= rank_i;
      end
   end

   generate
      if (NUM_DIMMS == 1) begin : g_one_dimm
         assign same_dimm = 1'b1;
      end else begin : g_multi_dimm
         assign same_dimm = (dimm_i == last_dimm);
      end
      if (RANKS_PER_DIMM == 1) begin : g_one_rank
         assign same_rank = same_dimm;
      end else begin : g_multi_rank
         assign same_rank = same_dimm && (rank_i == last_rank);
      end
   endgenerate

   always_comb begin
      if (same_rank)
         need = same_code_i ? AGE_W'(WR_SAME_HI) : AGE_W'(WR_SAME_LO);
      else if (same_dimm)
         need = AGE_W'(rank_code_i) + AGE_W'(WR_GAP_BASE);
      else
         need = AGE_W'(dimm_code_i) + AGE_W'(WR_GAP_BASE);
      ok_o = !seen || (age >= need);
   end

   p_wr_back2back_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire_i |=> !wr_fire_i);

endmodule

// File: rtl/dsg_act_window.sv
module dsg_act_window #(
   parameter int WIN_ACTS = 4,
   parameter int GAP_W    = 3,
   parameter int WIN_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire_i,
   input  logic [GAP_W-1:0] gap_i,
   input  logic [WIN_W-1:0] win_i,
   output logic             ok_o
);
   localparam int AGE_W = (WIN_W > GAP_W) ? WIN_W : GAP_W;
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   logic [AGE_W-1:0]    age_q [WIN_ACTS];
   logic [WIN_ACTS-1:0] vld_q;
   logic                gap_ok;
   logic                win_ok;

   initial begin
      assert (WIN_ACTS >= 1) else $error("dsg_act_window: WIN_ACTS must be positive");
   end

   function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
      return (a == AGE_MAX) ? a : a + AGE_W'(1);
   endfunction

   // entry 0 is the newest activate, entry WIN_ACTS-1 the oldest kept
   generate
      for (genvar i = 0; i < WIN_ACTS; i++) begin : g_slot
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  age_q[0] <= '0;
                  vld_q[0] <= 1'b0;
               end else if (act_fire_i) begin
                  age_q[0] <= AGE_W'(1);
                  vld_q[0] <= 1'b1;
               end else if (vld_q[0]) begin
                  age_q[0] <= sat_inc(age_q[0]);
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  age_q[i] <= '0;
                  vld_q[i] <= 1'b0;
               end else if (act_fire_i) begin
                  age_q[i] <= sat_inc(age_q[i-1]);
                  vld_q[i] <= vld_q[i-1];
               end else if (vld_q[i]) begin
                  age_q[i] <= sat_inc(age_q[i]);
               end
            end

            p_hist_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
               vld_q[i] |-> (vld_q[i-1] && (age_q[i] >= age_q[i-1])));
         end
      end
   endgenerate

   always_comb begin
      gap_ok = !vld_q[0] || (age_q[0] >= AGE_W'(gap_i));
      win_ok = (win_i == '0) || !vld_q[WIN_ACTS-1] ||
               (age_q[WIN_ACTS-1] >= AGE_W'(win_i));
      ok_o   = gap_ok && win_ok;
   end

   p_act_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_fire_i && (gap_i >= GAP_W'(2)))
      |=> (!act_fire_i || !$stable(gap_i)));

endmodule

// File: rtl/dram_spacing_gate.sv
module dram_spacing_gate
   import dsg_pkg::*;
#(
   parameter int NUM_DIMMS      = 2,
   parameter int RANKS_PER_DIMM = 2,
   parameter int WIN_ACTS       = 4,
   localparam int DIMM_W        = (NUM_DIMMS > 1) ? $clog2(NUM_DIMMS) : 1,
   localparam int RANK_W        = (RANKS_PER_DIMM > 1) ? $clog2(RANKS_PER_DIMM) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CFG_BITS-1:0] timing_word,
   input  logic                cmd_valid,
   input  logic [1:0]          cmd_type,
   input  logic [DIMM_W-1:0]   dimm_id,
   input  logic [RANK_W-1:0]   rank_id,
   output logic                issue_ok
);
   localparam int NUM_RANKS = NUM_DIMMS * RANKS_PER_DIMM;
   localparam int RIDX_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;

   dsg_cfg_t             cfg;
   dsg_cmd_e             cmd;
   logic [RIDX_W-1:0]    flat_idx;
   logic                 cas_ok;
   logic                 wr_ok;
   logic                 act_ok_sel;
   logic [NUM_RANKS-1:0] act_ok_vec;
   logic [NUM_RANKS-1:0] act_fire_vec;
   logic                 fire;
   logic                 cas_fire;
   logic                 wr_fire;

   initial begin
      assert (NUM_DIMMS >= 1 && RANKS_PER_DIMM >= 1)
         else $error("dram_spacing_gate: need at least one DIMM and rank");
      assert (WIN_ACTS >= 1) else $error("dram_spacing_gate: WIN_ACTS must be positive");
   end

   assign cfg      = dsg_cfg_t'(timing_word);
   assign cmd      = dsg_cmd_e'(cmd_type);
   assign flat_idx = RIDX_W'(dimm_id) * RIDX_W'(RANKS_PER_DIMM) + RIDX_W'(rank_id);

   always_comb begin
      act_ok_sel = 1'b1;
      for (int r = 0; r < NUM_RANKS; r++) begin
         if (flat_idx == RIDX_W'(r)) act_ok_sel = act_ok_vec[r];
      end
   end

   always_comb begin
      unique case (cmd)
         CMD_ACT: issue_ok = act_ok_sel;
         CMD_RD:  issue_ok = cas_ok;
         CMD_WR:  issue_ok = cas_ok && wr_ok;
         default: issue_ok = 1'b1;
      endcase
   end

   assign fire     = cmd_valid && issue_ok;
   assign cas_fire = fire && ((cmd == CMD_RD) || (cmd == CMD_WR));
   assign wr_fire  = fire && (cmd == CMD_WR);

   dsg_cas_gate #(.SET_W(5), .MIN_SET(CAS_MIN_SET)) u_cas (
      .clk        (clk),
      .rst_n      (rst_n),
      .cas_set_i  (cfg.cas_set),
      .cas_fire_i (cas_fire),
      .ok_o       (cas_ok)
   );

   dsg_wr_gate #(
      .NUM_DIMMS      (NUM_DIMMS),
      .RANKS_PER_DIMM (RANKS_PER_DIMM),
      .DIMM_W         (DIMM_W),
      .RANK_W         (RANK_W),
      .CODE_W         (3)
   ) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .dimm_i      (dimm_id),
      .rank_i      (rank_id),
      .same_code_i (cfg.wr_same),
      .rank_code_i (cfg.wr_rank),
      .dimm_code_i (cfg.wr_dimm),
      .wr_fire_i   (wr_fire),
      .ok_o        (wr_ok)
   );

   generate
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
         assign act_fire_vec[r] = fire && (cmd == CMD_ACT) && (flat_idx == RIDX_W'(r));

         dsg_act_window #(.WIN_ACTS(WIN_ACTS), .GAP_W(3), .WIN_W(6)) u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_fire_i (act_fire_vec[r]),
            .gap_i      (cfg.act_gap),
            .win_i      (cfg.faw_len),
            .ok_o       (act_ok_vec[r])
         );
      end
   endgenerate

   p_rsv_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RSV) |-> issue_ok);

   p_single_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_fire_vec));

endmodule

// File: tb/tb_dram_spacing_gate.sv
module tb_dram_spacing_gate;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] T_ACT = 2'd0, T_RD = 2'd1, T_WR = 2'd2, T_RSV = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] timing_word = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_type = '0;
   logic [0:0]  dimm_id = '0;
   logic [0:0]  rank_id = '0;
   logic        issue_ok;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_spacing_gate dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .timing_word (timing_word),
      .cmd_valid   (cmd_valid),
      .cmd_type    (cmd_type),
      .dimm_id     (dimm_id),
      .rank_id     (rank_id),
      .issue_ok    (issue_ok)
   );

   function automatic logic [20:0] mk(input int cas, input int wd, input int wrk,
                                      input int ws, input int gap, input int win);
      return {5'(cas), 3'(wd), 3'(wrk), 1'(ws), 3'(gap), 6'(win)};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [20:0] cfg);
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      timing_word = cfg;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle: drive at falling edge, read the grant before the rising edge
   task automatic step(input logic v, input logic [1:0] t, input int d, input int r,
                       output logic ok);
      @(negedge clk);
      cmd_valid = v;
      cmd_type  = t;
      dimm_id   = 1'(d);
      rank_id   = 1'(r);
      #1;
      ok = issue_ok;
      cyc++;
   endtask

   task automatic issue(input string tag, input logic [1:0] t, input int d, input int r,
                        output int when);
      logic ok;
      step(1'b1, t, d, r, ok);
      chk(tag, int'(ok), 1);
      when = cyc;
   endtask

   task automatic poll(input logic [1:0] t, input int d, input int r, output int when);
      logic ok;
      when = -1000;
      for (int k = 0; k < 80; k++) begin
         step(1'b1, t, d, r, ok);
         if (ok) begin
            when = cyc;
            break;
         end
      end
   endtask

   task automatic gap_test(input string tag, input logic [20:0] cfg,
                           input logic [1:0] t1, input int d1, input int r1,
                           input logic [1:0] t2, input int d2, input int r2,
                           input int exp);
      int a, b;
      do_reset(cfg);
      issue(tag, t1, d1, r1, a);
      poll(t2, d2, r2, b);
      chk(tag, b - a, exp);
   endtask

   task automatic t_reset;
      logic ok;
      do_reset('0);
      step(1'b0, T_ACT, 0, 0, ok); chk("R1 act after reset", int'(ok), 1);
      step(1'b0, T_RD, 1, 1, ok);  chk("R1 rd after reset", int'(ok), 1);
      step(1'b0, T_WR, 0, 1, ok);  chk("R1 wr after reset", int'(ok), 1);
      gap_test("R1 rd-rd zero cfg", '0, T_RD, 0, 0, T_RD, 0, 0, 1);
   endtask

   task automatic t_cas;
      gap_test("R2 cas set 4", mk(4, 0, 0, 0, 0, 0), T_RD, 0, 0, T_RD, 1, 1, 5);
      gap_test("R2 cas set 31", mk(31, 0, 0, 0, 0, 0), T_RD, 0, 0, T_RD, 0, 1, 32);
      gap_test("R2 cas set 3 rd-wr", mk(3, 0, 0, 0, 0, 0), T_RD, 0, 0, T_WR, 1, 0, 4);
      gap_test("R3 cas set 2", mk(2, 0, 0, 0, 0, 0), T_RD, 0, 0, T_RD, 0, 0, 1);
      gap_test("R3 cas set 1", mk(1, 0, 0, 0, 0, 0), T_WR, 0, 0, T_RD, 0, 0, 1);
   endtask

   task automatic t_write;
      gap_test("R4 dimm code 5", mk(0, 5, 0, 0, 0, 0), T_WR, 0, 0, T_WR, 1, 1, 7);
      gap_test("R4 dimm code 0", mk(0, 0, 7, 1, 0, 0), T_WR, 0, 1, T_WR, 1, 1, 2);
      gap_test("R4 dimm code 7", mk(0, 7, 0, 0, 0, 0), T_WR, 1, 0, T_WR, 0, 0, 9);
      gap_test("R5 rank code 7", mk(0, 0, 7, 0, 0, 0), T_WR, 0, 0, T_WR, 0, 1, 9);
      gap_test("R5 rank code 3", mk(0, 7, 3, 1, 0, 0), T_WR, 1, 1, T_WR, 1, 0, 5);
      gap_test("R6 same rank bit 0", mk(0, 7, 7, 0, 0, 0), T_WR, 1, 1, T_WR, 1, 1, 4);
      gap_test("R6 same rank bit 1", mk(0, 7, 7, 1, 0, 0), T_WR, 0, 0, T_WR, 0, 0, 6);
   endtask

   task automatic t_read_between;
      int a, b, c;
      do_reset(mk(0, 7, 7, 1, 0, 0));
      issue("R10 first wr", T_WR, 0, 0, a);
      issue("R10 rd in gap", T_RD, 1, 0, c);
      chk("R10 rd one cycle later", c - a, 1);
      poll(T_WR, 0, 0, b);
      chk("R10 wr gap kept across rd", b - a, 6);
   endtask

   task automatic t_act;
      gap_test("R7 gap 5 same rank", mk(0, 0, 0, 0, 5, 0), T_ACT, 0, 0, T_ACT, 0, 0, 5);
      gap_test("R7 gap 5 other rank", mk(0, 0, 0, 0, 5, 0), T_ACT, 0, 0, T_ACT, 0, 1, 1);
      gap_test("R7 gap 0", mk(0, 0, 0, 0, 0, 0), T_ACT, 1, 1, T_ACT, 1, 1, 1);
   endtask

   task automatic t_window;
      int a, b, w;
      logic ok;
      do_reset(mk(0, 0, 0, 0, 0, 10));
      issue("R8 act 1", T_ACT, 0, 0, a);
      for (int i = 0; i < 3; i++) issue("R8 act 2-4", T_ACT, 0, 0, w);
      step(1'b0, T_ACT, 1, 1, ok);
      chk("R8 other rank free", int'(ok), 1);
      poll(T_ACT, 0, 0, b);
      chk("R8 fifth act at window", b - a, 10);

      do_reset(mk(0, 0, 0, 0, 2, 10));
      issue("R8 paced act 1", T_ACT, 1, 0, a);
      for (int i = 0; i < 3; i++) poll(T_ACT, 1, 0, w);
      chk("R8 fourth paced act", w - a, 6);
      poll(T_ACT, 1, 0, b);
      chk("R8 paced fifth act", b - a, 10);

      do_reset(mk(0, 0, 0, 0, 0, 0));
      for (int i = 0; i < 5; i++) issue("R8 window off back-to-back", T_ACT, 0, 1, w);
   endtask

   task automatic t_valid;
      int a, b;
      logic ok;
      do_reset(mk(0, 0, 0, 0, 5, 0));
      step(1'b0, T_ACT, 0, 0, ok);
      chk("R9 invalid act granted", int'(ok), 1);
      issue("R9 invalid left no history", T_ACT, 0, 0, a);
      step(1'b1, T_ACT, 0, 0, ok);
      chk("R9 blocked act", int'(ok), 0);
      step(1'b1, T_RSV, 0, 0, ok);
      chk("R9 reserved always granted", int'(ok), 1);
      poll(T_ACT, 0, 0, b);
      chk("R9 rejected request no effect", b - a, 5);
   endtask

   initial begin
      t_reset();
      t_cas();
      t_write();
      t_read_between();
      t_act();
      t_window();
      t_valid();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule